// File: doc/BRIEF.md
# Redundant Stream Duplicate Eliminator

This block sits where two or more copies of a protected stream come back together. Every frame arrives with a stream handle and a 16-bit sequence number. For each stream the block keeps an anchor (the highest sequence number accepted so far) and a history bitmap of recently accepted numbers behind it. From these it decides whether to forward or drop each arrival. The first copy of a number is forwarded. Later copies are dropped.

Numbers ahead of the anchor are forwarded at once, including when some numbers are skipped. The block never holds a frame back to wait for missing ones. Arrivals behind the anchor but inside the history window are forwarded as out-of-order if they have not been seen. Arrivals further back are dropped as late. Each decision appears one cycle later as a registered result with a kind code. Counters keep totals of forwarded frames, duplicates, out-of-order arrivals, late arrivals and sequence gaps.

History for a stream is dropped in three cases: on reset, on an explicit clear command for that stream, or when that stream has been silent for longer than a set number of cycles. The next frame on the stream then starts afresh.

Top module: `dedup_eliminator`

## Requirements
- R1: Each frame presented with `in_valid` produces exactly one result one clock later: `out_valid` is high, and `out_stream` and `out_seq` carry the frame's handle and number. `out_valid` is low in every other cycle.
- R2: A frame on a stream with no history is forwarded with kind 0 (first) and becomes that stream's anchor.
- R3: A number 1 ahead of the anchor (modulo 65536) is forwarded with kind 1 (in sequence). A number 2 to 32767 ahead is forwarded at once with kind 2 (gap). In both cases the number becomes the new anchor.
- R4: A number equal to the anchor, or behind it by less than HIST and already accepted, is dropped with kind 4 (duplicate).
- R5: A number behind the anchor by 1 to HIST-1 and not yet accepted is forwarded with kind 3 (out of order), and the anchor is unchanged.
- R6: A number behind the anchor by HIST or more, where a difference of exactly 32768 counts as behind, is dropped with kind 5 (late).
- R7: Distances are taken modulo 65536, so 0 after 65535 is in sequence.
- R8: Streams are independent: a frame on one stream never changes the decision for another stream.
- R9: `clr_valid` erases the history of `clr_stream`. A frame for that stream in the same cycle, or in any later cycle, is treated as first.
- R10: If more than IDLE_CYCLES cycles pass between two frames of a stream, the later frame is treated as first. A frame exactly IDLE_CYCLES cycles after the previous one still uses the history.
- R11: Each counter rises by exactly one per matching result, in the same cycle the result appears. `cnt_fwd` counts kinds 0 to 3, `cnt_dup` kind 4, `cnt_ooo` kind 3, `cnt_late` kind 5 and `cnt_gap` kind 2.
- R12: While `rst` is high, `out_valid`, `out_fwd` and all counters are 0, and all stream histories are erased.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Frame present this cycle |
| in_stream | input | SW | Stream handle of the frame |
| in_seq | input | 16 | Sequence number of the frame |
| clr_valid | input | 1 | Erase history of one stream |
| clr_stream | input | SW | Stream whose history is erased |
| out_valid | output | 1 | Result present |
| out_fwd | output | 1 | 1 = forward the frame, 0 = discard |
| out_kind | output | 3 | Kind code 0..5 as listed in R2 to R6 |
| out_stream | output | SW | Stream handle of the result |
| out_seq | output | 16 | Sequence number of the result |
| cnt_fwd | output | CNT_W | Forwarded frames |
| cnt_dup | output | CNT_W | Duplicates dropped |
| cnt_ooo | output | CNT_W | Out-of-order frames forwarded |
| cnt_late | output | CNT_W | Late frames dropped |
| cnt_gap | output | CNT_W | Forwards that skipped numbers |

## Verification
A wrong anchor or wrong history bit does not show right away. It shows on the next arrival for that stream that falls inside the window, as a wrong kind and a wrong forward decision, and the matching counter is then off by one in the same cycle. A bad idle or clear state shows as a first-kind result where a duplicate was expected, or the other way round. The reference model is compared on every clock, so any such error is caught in the cycle of the first affected result. Checking only final counter totals would let errors hide.

// File: rtl/dedup_pkg.sv
package dedup_pkg;
  localparam int SEQ_W = 16;

  typedef enum logic [2:0] {
    K_FIRST = 3'd0,
    K_INSEQ = 3'd1,
    K_GAP   = 3'd2,
    K_OOO   = 3'd3,
    K_DUP   = 3'd4,
    K_LATE  = 3'd5
  } kind_e;

  localparam int EV_FWD  = 0;
  localparam int EV_DUP  = 1;
  localparam int EV_OOO  = 2;
  localparam int EV_LATE = 3;
  localparam int EV_GAP  = 4;
  localparam int NUM_EV  = 5;
endpackage

// File: rtl/dedup_classify.sv
module dedup_classify
  import dedup_pkg::*;
#(
  parameter int HIST = 32
) (
  input  logic             hist_valid,
  input  logic [SEQ_W-1:0] anchor,
  input  logic [HIST-1:0]  bitmap,
  input  logic [SEQ_W-1:0] seq,
  output kind_e            kind,
  output logic             accept,
  output logic [SEQ_W-1:0] next_anchor,
  output logic [HIST-1:0]  next_bitmap
);
  localparam int IW = (HIST > 1) ? $clog2(HIST) : 1;
  localparam logic [HIST-1:0]  ONE    = HIST'(1);
  localparam logic [SEQ_W-1:0] HIST_D = SEQ_W'(HIST);

  logic [SEQ_W-1:0] ahead;
  logic [SEQ_W-1:0] behind;

  assign ahead  = seq - anchor;
  assign behind = anchor - seq;

  always_comb begin
    kind        = K_DUP;
    next_anchor = anchor;
    next_bitmap = bitmap;
    if (!hist_valid) begin
      kind        = K_FIRST;
      next_anchor = seq;
      next_bitmap = ONE;
    end else if (ahead == '0) begin
      kind = K_DUP;
    end else if (!ahead[SEQ_W-1]) begin
      kind        = (ahead == SEQ_W'(1)) ? K_INSEQ : K_GAP;
      next_anchor = seq;
      if (ahead >= HIST_D) next_bitmap = ONE;
      else                 next_bitmap = (bitmap << ahead) | ONE;
    end else if (behind >= HIST_D) begin
      kind = K_LATE;
    end else if (bitmap[behind[IW-1:0]]) begin
      kind = K_DUP;
    end else begin
      kind        = K_OOO;
      next_bitmap = bitmap | (ONE << behind[IW-1:0]);
    end
  end

  assign accept = (kind != K_DUP) && (kind != K_LATE);
endmodule

// File: rtl/dedup_idle_timer.sv
module dedup_idle_timer #(
  parameter int IDLE_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic touch,
  output logic expired
);
  localparam int TW = $clog2(IDLE_CYCLES + 1);
  localparam logic [TW-1:0] LIMIT = TW'(IDLE_CYCLES);

  logic [TW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst)                   count_q <= '0;
    else if (touch)            count_q <= '0;
    else if (count_q != LIMIT) count_q <= count_q + 1'b1;
  end

  assign expired = (count_q == LIMIT);
endmodule

// File: rtl/dedup_counters.sv
module dedup_counters #(
  parameter int NEV = 5,
  parameter int CW  = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NEV-1:0]  ev,
  output logic [NEV*CW-1:0] cnt
);
  for (genvar i = 0; i < NEV; i++) begin : g_cnt
    logic [CW-1:0] c_q;
    always_ff @(posedge clk) begin
      if (rst)        c_q <= '0;
      else if (ev[i]) c_q <= c_q + 1'b1;
    end
    assign cnt[i*CW +: CW] = c_q;
  end
endmodule

// File: rtl/dedup_eliminator.sv
module dedup_eliminator
  import dedup_pkg::*;
#(
  parameter int NUM_STREAMS = 8,
  parameter int HIST        = 32,
  parameter int IDLE_CYCLES = 1000,
  parameter int CNT_W       = 32,
  localparam int SW = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [SW-1:0]    in_stream,
  input  logic [15:0]      in_seq,
  input  logic             clr_valid,
  input  logic [SW-1:0]    clr_stream,
  output logic             out_valid,
  output logic             out_fwd,
  output logic [2:0]       out_kind,
  output logic [SW-1:0]    out_stream,
  output logic [15:0]      out_seq,
  output logic [CNT_W-1:0] cnt_fwd,
  output logic [CNT_W-1:0] cnt_dup,
  output logic [CNT_W-1:0] cnt_ooo,
  output logic [CNT_W-1:0] cnt_late,
  output logic [CNT_W-1:0] cnt_gap
);
  // Per-stream history storage (no reset, single write port)
  logic [SEQ_W-1:0] anchor_mem [NUM_STREAMS];
  logic [HIST-1:0]  bitmap_mem [NUM_STREAMS];
  logic [NUM_STREAMS-1:0] live_q;
  logic [NUM_STREAMS-1:0] expired;

  logic             eff_valid;
  kind_e            kind;
  logic             accept;
  logic [SEQ_W-1:0] nxt_anchor;
  logic [HIST-1:0]  nxt_bitmap;
  logic [NUM_EV-1:0] ev;
  logic [NUM_EV*CNT_W-1:0] cnt_bus;

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_idle
    dedup_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .touch   (in_valid && (in_stream == SW'(s))),
      .expired (expired[s])
    );
  end

  assign eff_valid = live_q[in_stream] && !expired[in_stream] &&
                     !(clr_valid && (clr_stream == in_stream));

  dedup_classify #(.HIST(HIST)) u_cls (
    .hist_valid  (eff_valid),
    .anchor      (anchor_mem[in_stream]),
    .bitmap      (bitmap_mem[in_stream]),
    .seq         (in_seq),
    .kind        (kind),
    .accept      (accept),
    .next_anchor (nxt_anchor),
    .next_bitmap (nxt_bitmap)
  );

  always_ff @(posedge clk) begin
    if (in_valid) begin
      anchor_mem[in_stream] <= nxt_anchor;
      bitmap_mem[in_stream] <= nxt_bitmap;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
    end else begin
      if (clr_valid) live_q[clr_stream] <= 1'b0;
      if (in_valid)  live_q[in_stream]  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_fwd    <= 1'b0;
      out_kind   <= '0;
      out_stream <= '0;
      out_seq    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_fwd    <= accept;
        out_kind   <= kind;
        out_stream <= in_stream;
        out_seq    <= in_seq;
      end
    end
  end

  always_comb begin
    ev          = '0;
    ev[EV_FWD]  = in_valid && accept;
    ev[EV_DUP]  = in_valid && (kind == K_DUP);
    ev[EV_OOO]  = in_valid && (kind == K_OOO);
    ev[EV_LATE] = in_valid && (kind == K_LATE);
    ev[EV_GAP]  = in_valid && (kind == K_GAP);
  end

  dedup_counters #(.NEV(NUM_EV), .CW(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .ev  (ev),
    .cnt (cnt_bus)
  );

  assign cnt_fwd  = cnt_bus[EV_FWD*CNT_W  +: CNT_W];
  assign cnt_dup  = cnt_bus[EV_DUP*CNT_W  +: CNT_W];
  assign cnt_ooo  = cnt_bus[EV_OOO*CNT_W  +: CNT_W];
  assign cnt_late = cnt_bus[EV_LATE*CNT_W +: CNT_W];
  assign cnt_gap  = cnt_bus[EV_GAP*CNT_W  +: CNT_W];
endmodule

// File: rtl/dedup_checker.sv
module dedup_checker #(
  parameter int SW = 3,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [SW-1:0] in_stream,
  input logic [15:0]   in_seq,
  input logic          out_valid,
  input logic          out_fwd,
  input logic [2:0]    out_kind,
  input logic [SW-1:0] out_stream,
  input logic [15:0]   out_seq,
  input logic [CW-1:0] cnt_fwd,
  input logic [CW-1:0] cnt_dup
);
  // R1
  result_follow_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid && !rst));

  // R1
  result_id_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_seq == $past(in_seq)) && (out_stream == $past(in_stream)));

  // R4
  dup_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_kind == 3'd4)) |-> !out_fwd);

  // R6
  late_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_kind == 3'd5)) |-> !out_fwd);

  // R3
  gap_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_kind == 3'd2)) |-> out_fwd);

  // R11
  dup_count_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_kind == 3'd4)) |-> (cnt_dup == $past(cnt_dup) + 1'b1));

  // R11
  fwd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(cnt_fwd));
endmodule

bind dedup_eliminator dedup_checker #(.SW(SW), .CW(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_stream  (in_stream),
  .in_seq     (in_seq),
  .out_valid  (out_valid),
  .out_fwd    (out_fwd),
  .out_kind   (out_kind),
  .out_stream (out_stream),
  .out_seq    (out_seq),
  .cnt_fwd    (cnt_fwd),
  .cnt_dup    (cnt_dup)
);

// File: tb/tb_dedup_eliminator.sv
module tb_dedup_eliminator;
  localparam int NS   = 4;
  localparam int HIST = 32;
  localparam int IDLE = 20;
  localparam int CW   = 16;
  localparam int SW   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [SW-1:0] in_stream = '0;
  logic [15:0] in_seq = '0;
  logic clr_valid = 1'b0;
  logic [SW-1:0] clr_stream = '0;
  logic out_valid, out_fwd;
  logic [2:0] out_kind;
  logic [SW-1:0] out_stream;
  logic [15:0] out_seq;
  logic [CW-1:0] cnt_fwd, cnt_dup, cnt_ooo, cnt_late, cnt_gap;

  always #2 clk = ~clk;

  dedup_eliminator #(.NUM_STREAMS(NS), .HIST(HIST), .IDLE_CYCLES(IDLE), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_stream(in_stream), .in_seq(in_seq),
    .clr_valid(clr_valid), .clr_stream(clr_stream), .out_valid(out_valid), .out_fwd(out_fwd),
    .out_kind(out_kind), .out_stream(out_stream), .out_seq(out_seq), .cnt_fwd(cnt_fwd),
    .cnt_dup(cnt_dup), .cnt_ooo(cnt_ooo), .cnt_late(cnt_late), .cnt_gap(cnt_gap));

  int checks = 0;
  int fails = 0;
  string phase = "R12";

  // reference model state
  bit hv[NS];
  int anc[NS];
  int last[NS];
  int seen[NS][$];
  int cyc = 0;
  bit e_valid = 0, e_fwd = 0, e_rst = 1;
  int e_kind = 0, e_stream = 0, e_seq = 0;
  int e_cnt[5] = '{default: 0};

  function automatic string kind_req(int k);
    case (k)
      0: return "R2";
      1, 2: return "R3";
      3: return "R5";
      4: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] cycle %0d: actual %0d expected %0d", req, phase, cyc, act, exp);
    end
  endtask

  task automatic compare();
    string rq;
    rq = e_rst ? "R12" : "R1";
    chk(out_valid == e_valid, rq, out_valid, e_valid);
    if (e_valid) begin
      chk(out_fwd == e_fwd, kind_req(e_kind), out_fwd, e_fwd);
      chk(int'(out_kind) == e_kind, kind_req(e_kind), out_kind, e_kind);
      chk(int'(out_stream) == e_stream, "R1", out_stream, e_stream);
      chk(int'(out_seq) == e_seq, "R1", out_seq, e_seq);
    end
    rq = e_rst ? "R12" : "R11";
    chk(int'(cnt_fwd)  == e_cnt[0], rq, cnt_fwd,  e_cnt[0]);
    chk(int'(cnt_dup)  == e_cnt[1], rq, cnt_dup,  e_cnt[1]);
    chk(int'(cnt_ooo)  == e_cnt[2], rq, cnt_ooo,  e_cnt[2]);
    chk(int'(cnt_late) == e_cnt[3], rq, cnt_late, e_cnt[3]);
    chk(int'(cnt_gap)  == e_cnt[4], rq, cnt_gap,  e_cnt[4]);
  endtask

  function automatic bit in_seen(int s, int q);
    foreach (seen[s][i]) if (seen[s][i] == q) return 1;
    return 0;
  endfunction

  function automatic void prune(int s);
    for (int i = seen[s].size() - 1; i >= 0; i--)
      if (((anc[s] - seen[s][i]) & 16'hFFFF) >= HIST) seen[s].delete(i);
  endfunction

  task automatic step(bit r, bit v, int s, int q, bit cv, int cs);
    bit h;
    int k, d;
    @(negedge clk);
    compare();
    q = q & 16'hFFFF;
    rst = r; in_valid = v; in_stream = SW'(s); in_seq = 16'(q);
    clr_valid = cv; clr_stream = SW'(cs);
    e_rst = r;
    e_valid = 0;
    if (r) begin
      for (int i = 0; i < NS; i++) begin hv[i] = 0; seen[i].delete(); end
      for (int i = 0; i < 5; i++) e_cnt[i] = 0;
    end else begin
      if (v) begin
        h = hv[s];
        if (cv && cs == s) h = 0;
        if (h && (cyc - last[s] > IDLE)) h = 0;
        if (!h) begin
          k = 0; anc[s] = q; seen[s].delete(); seen[s].push_back(q);
        end else begin
          d = (q - anc[s]) & 16'hFFFF;
          if (d == 0) k = 4;
          else if (d < 32768) begin
            k = (d == 1) ? 1 : 2;
            anc[s] = q; seen[s].push_back(q); prune(s);
          end else if (65536 - d >= HIST) k = 5;
          else if (in_seen(s, q)) k = 4;
          else begin k = 3; seen[s].push_back(q); end
        end
        hv[s] = 1; last[s] = cyc;
        e_valid = 1; e_kind = k; e_stream = s; e_seq = q; e_fwd = (k <= 3);
        if (k <= 3) e_cnt[0] = (e_cnt[0] + 1) & 16'hFFFF;
        if (k == 4) e_cnt[1] = (e_cnt[1] + 1) & 16'hFFFF;
        if (k == 3) e_cnt[2] = (e_cnt[2] + 1) & 16'hFFFF;
        if (k == 5) e_cnt[3] = (e_cnt[3] + 1) & 16'hFFFF;
        if (k == 2) e_cnt[4] = (e_cnt[4] + 1) & 16'hFFFF;
      end
      if (cv && !(v && cs == s)) hv[cs] = 0;
    end
    cyc++;
  endtask

  task automatic send(int s, int q);
    step(0, 1, s, q, 0, 0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 [watchdog] cycle %0d: actual %0d expected %0d", cyc, 0, 1);
    finish_run();
  end

  initial begin
    int nxt[NS];
    int r, s, q;
    phase = "R12";
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0);
    idle(1);

    phase = "R2-R6 directed";
    send(0, 100); send(0, 101); send(0, 101); send(0, 100);
    send(0, 104); send(0, 103); send(0, 103); send(0, 102); send(0, 105);
    send(0, 105 - 32); send(0, 105 - 31); send(0, 105 - 31);
    send(0, 105 + 32768); send(0, 205); send(0, 204); send(0, 105);

    phase = "R7";
    send(1, 65534); send(1, 65535); send(1, 0); send(1, 65535); send(1, 65533); send(1, 1);

    phase = "R8";
    send(2, 500); send(3, 500); send(2, 501); send(3, 500); send(2, 500); send(3, 10);

    phase = "R9";
    step(0, 0, 0, 0, 1, 0); send(0, 205);
    step(0, 1, 1, 1, 1, 1); send(1, 1);

    phase = "R10";
    send(2, 700); idle(IDLE - 1); send(2, 700);
    idle(IDLE); send(2, 700); send(2, 700);

    phase = "R11 random";
    for (int i = 0; i < NS; i++) nxt[i] = (i == 1) ? 65500 : i * 1000;
    for (int n = 0; n < 4000; n++) begin
      if (n % 700 == 699) idle(IDLE + 3);
      s = $urandom_range(0, NS - 1);
      r = $urandom_range(0, 9);
      if (r < 4) begin q = nxt[s]; nxt[s] = (nxt[s] + 1) & 16'hFFFF; send(s, q); end
      else if (r < 7) send(s, nxt[s] - 1 - $urandom_range(0, 5));
      else if (r == 7) send(s, nxt[s] - $urandom_range(20, 45));
      else if (r == 8) begin q = nxt[s] + $urandom_range(1, 4); nxt[s] = (q + 1) & 16'hFFFF; send(s, q); end
      else step(0, $urandom_range(0, 1), s, nxt[s] - 1, ($urandom_range(0, 4) == 0), $urandom_range(0, NS - 1));
    end

    phase = "R12 mid-run";
    step(1, 1, 0, 7, 0, 0); step(1, 0, 0, 0, 0, 0);
    send(0, 7); send(0, 7);
    idle(2);
    finish_run();
  end
endmodule